// File: doc/BRIEF.md
# SECDED-Protected Single-Port RAM with Error Injection

This block wraps a single-port on-chip memory with single-error-correct, double-error-detect protection. Each stored data word carries a set of check bits: Hamming bits plus one overall parity bit. With the default 16-bit data width that is 5 Hamming bits and 1 parity bit, 22 bits per word. On every memory read the block corrects a single flipped bit before it returns the data. It reports an uncorrectable double flip on a non-maskable interrupt line. It keeps a sticky correctable-error flag, the address of the most recent correctable error, and an event counter. When that counter reaches a programmable threshold, the block pulses an interrupt.

Software reaches both the memory and a small control register file over one bus with write enable, read enable, address and data. The most significant address bit selects the register file. A test-mode bit changes memory writes so that they update only the stored data bits and leave the old check bits in place. A later read of that word then sees a deliberately injected error, which lets software exercise the whole detection and reporting path.

Top module: `ecc_ram_top`

## Requirements
- R1: Outside test mode a memory write stores the data together with freshly computed check bits. A later read returns the same word and raises no error flag, even if the word previously held an injected error.
- R2: With CTRL bit 0 (test mode) set, a memory write replaces only the data bits and keeps the check bits already stored. Reads in test mode still detect and correct errors.
- R3: A read of a word whose stored data differs from its check bits in exactly one bit returns the corrected, originally encoded data.
- R4: A correctable error detected on a memory read sets STATUS bit 0. The flag stays set until software writes STATUS with bit 0 at 1. Writing 0 to that bit leaves it unchanged.
- R5: On each correctable error, register ERRADDR captures the memory address of that read. The register is read-only, so bus writes to it are ignored. An uncorrectable error does not update it.
- R6: A double-bit error sets STATUS bit 1 and drives `nmi_o` high while that bit is set. It does not set STATUS bit 0. Writing 1 to STATUS bit 1 clears the flag and drops `nmi_o`.
- R7: A read request (`bus_re` high, `bus_we` low) in cycle t gives `bus_rvalid` high with valid `bus_rdata` in cycle t+1. The STATUS, ERRADDR and COUNT updates caused by that read are visible from cycle t+2.
- R8: Each correctable error increments COUNT. When the incremented count is equal to or greater than a nonzero THRESH, `thr_irq_o` pulses for one cycle and COUNT returns to 0. A THRESH of 1 fires on the first error, and a THRESH of 0 never fires.
- R9: After reset, CTRL, STATUS, ERRADDR, COUNT and THRESH read 0, and `nmi_o`, `thr_irq_o` and `bus_rvalid` are low.
- R10: Address map: bus address bit 8 set selects the register file, with the register index in bits 2:0. CTRL=0, STATUS=1, ERRADDR=2, THRESH=3, COUNT=4. With bit 8 clear, bits 7:0 address the memory word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write request; takes priority over a read in the same cycle |
| bus_re | input | 1 | Read request |
| bus_addr | input | 9 | Bit 8 selects registers; otherwise the memory word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid while bus_rvalid is high |
| bus_rvalid | output | 1 | Read data valid, one cycle after the request |
| nmi_o | output | 1 | Uncorrectable-error interrupt, level |
| thr_irq_o | output | 1 | One-cycle pulse when the correctable count reaches the threshold |

## Verification
Plain round trips with all-zero, all-one and mixed words at the lowest, highest and middle addresses show that a normal write produces a consistent codeword. Single flips injected in the lowest and highest data bits show that correction locates the bit rather than returning the raw data, and that the address capture follows the latest failing word. A two-bit injection separates the uncorrectable path from the correctable one, since the correctable flag and the captured address must stay untouched. A series of repeated failing reads under thresholds of 2, 1 and 0 compares the interrupt pulses and the counter contents against a model of reach-and-restart counting.

// File: rtl/ecc_ram_pkg.sv
package ecc_ram_pkg;

   localparam int REG_IDX_W = 3;

   typedef enum logic [REG_IDX_W-1:0] {
      REG_CTRL  = 3'd0,
      REG_STAT  = 3'd1,
      REG_EADDR = 3'd2,
      REG_THR   = 3'd3,
      REG_CNT   = 3'd4
   } reg_idx_e;

   // number of Hamming bits needed to cover dw data bits
   function automatic int hamming_bits(int dw);
      int p;
      p = 1;
      for (int k = 0; k < 16; k++) begin
         if ((1 << p) < dw + p + 1) p = p + 1;
      end
      return p;
   endfunction

   // codeword position (1-based) of data bit j; powers of two hold check bits
   function automatic int data_pos(int j);
      int cnt;
      int res;
      cnt = 0;
      res = 0;
      for (int pos = 1; pos < 256; pos++) begin
         if ((pos & (pos - 1)) != 0) begin
            if (cnt == j) res = pos;
            cnt = cnt + 1;
         end
      end
      return res;
   endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc #(
   parameter int DW = 16,
   localparam int HW = ecc_ram_pkg::hamming_bits(DW),
   localparam int CW = HW + 1
) (
   input  logic [DW-1:0] data,
   output logic [CW-1:0] chk
);
   logic [HW-1:0] ham;

   always_comb begin
      ham = '0;
      for (int i = 0; i < HW; i++) begin
         for (int j = 0; j < DW; j++) begin
            if (((ecc_ram_pkg::data_pos(j) >> i) & 1) == 1) ham[i] = ham[i] ^ data[j];
         end
      end
   end

   // overall parity makes the full codeword even
   assign chk = {(^data) ^ (^ham), ham};

endmodule

// File: rtl/secded_dec.sv
module secded_dec #(
   parameter int DW = 16,
   localparam int HW = ecc_ram_pkg::hamming_bits(DW),
   localparam int CW = HW + 1
) (
   input  logic [DW-1:0] data,
   input  logic [CW-1:0] chk,
   output logic [DW-1:0] fixed,
   output logic          err_single,
   output logic          err_double
);
   logic [HW-1:0] syn;
   logic          par_bad;

   always_comb begin
      syn = chk[HW-1:0];
      for (int i = 0; i < HW; i++) begin
         for (int j = 0; j < DW; j++) begin
            if (((ecc_ram_pkg::data_pos(j) >> i) & 1) == 1) syn[i] = syn[i] ^ data[j];
         end
      end
   end

   assign par_bad    = (^data) ^ (^chk);
   // odd flip count: correctable (zero syndrome means the parity bit itself)
   assign err_single = par_bad;
   assign err_double = !par_bad && (syn != '0);

   for (genvar j = 0; j < DW; j++) begin : g_fix
      localparam logic [HW-1:0] POS = HW'(ecc_ram_pkg::data_pos(j));
      assign fixed[j] = data[j] ^ (par_bad && (syn == POS));
   end

endmodule

// File: rtl/ecc_store.sv
module ecc_store #(
   parameter int DW    = 16,
   parameter int CW    = 6,
   parameter int DEPTH = 256,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we_data,
   input  logic          we_chk,
   input  logic          re,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   input  logic [CW-1:0] wchk,
   output logic [DW-1:0] rdata,
   output logic [CW-1:0] rchk
);
   // data and check bits in separate arrays so either can be written alone
   logic [DW-1:0] dmem [DEPTH];
   logic [CW-1:0] cmem [DEPTH];

   always_ff @(posedge clk) begin
      if (we_data) dmem[addr] <= wdata;
      if (we_chk)  cmem[addr] <= wchk;
      if (re) begin
         rdata <= dmem[addr];
         rchk  <= cmem[addr];
      end
   end

endmodule

// File: rtl/ecc_csr.sv
module ecc_csr #(
   parameter int DW      = 16,
   parameter int AW      = 8,
   parameter int CNT_W   = 8,
   parameter int THR_RST = 0
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en,
   input  logic [ecc_ram_pkg::REG_IDX_W-1:0] wr_idx,
   input  logic [CNT_W-1:0]                  wr_data,
   input  logic [ecc_ram_pkg::REG_IDX_W-1:0] rd_idx,
   input  logic                              ce_evt,
   input  logic                              ue_evt,
   input  logic [AW-1:0]                     evt_addr,
   output logic [DW-1:0]                     rd_data,
   output logic                              test_mode,
   output logic                              nmi_o,
   output logic                              thr_irq_o
);
   import ecc_ram_pkg::*;

   logic             ce_flag, ue_flag;
   logic [AW-1:0]    err_addr;
   logic [CNT_W-1:0] thr, cnt;
   logic [CNT_W:0]   cnt_inc;
   logic             wr_ctrl, wr_stat, wr_thr, fire;

   assign wr_ctrl = wr_en && (wr_idx == REG_CTRL);
   assign wr_stat = wr_en && (wr_idx == REG_STAT);
   assign wr_thr  = wr_en && (wr_idx == REG_THR);
   assign cnt_inc = {1'b0, cnt} + 1'b1;
   assign fire    = ce_evt && (thr != '0) && (cnt_inc >= {1'b0, thr});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         test_mode <= 1'b0;
         thr       <= CNT_W'(THR_RST);
      end else begin
         if (wr_ctrl) test_mode <= wr_data[0];
         if (wr_thr)  thr       <= wr_data;
      end
   end

   // sticky flags: a new event wins over a same-cycle clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ce_flag  <= 1'b0;
         ue_flag  <= 1'b0;
         err_addr <= '0;
      end else begin
         if (ce_evt)                     ce_flag <= 1'b1;
         else if (wr_stat && wr_data[0]) ce_flag <= 1'b0;
         if (ue_evt)                     ue_flag <= 1'b1;
         else if (wr_stat && wr_data[1]) ue_flag <= 1'b0;
         if (ce_evt) err_addr <= evt_addr;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         thr_irq_o <= 1'b0;
      end else begin
         thr_irq_o <= fire;
         if (fire)                         cnt <= '0;
         else if (ce_evt && (cnt != '1))   cnt <= cnt_inc[CNT_W-1:0];
      end
   end

   assign nmi_o = ue_flag;

   always_comb begin
      rd_data = '0;
      case (rd_idx)
         REG_CTRL:  rd_data[0]       = test_mode;
         REG_STAT:  rd_data[1:0]     = {ue_flag, ce_flag};
         REG_EADDR: rd_data[AW-1:0]  = err_addr;
         REG_THR:   rd_data[CNT_W-1:0] = thr;
         REG_CNT:   rd_data[CNT_W-1:0] = cnt;
         default:   rd_data = '0;
      endcase
   end

   p_ce_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_flag && !(wr_stat && wr_data[0])) |=> ce_flag);

   p_addr_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ce_evt |=> (err_addr == $past(evt_addr)));

   p_nmi_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ue_evt |=> nmi_o);

   p_ue_no_ce_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ue_evt && !ce_flag) |=> !ce_flag);

   p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      thr_irq_o |-> $past(ce_evt));

endmodule

// File: rtl/ecc_ram_top.sv
module ecc_ram_top #(
   parameter int DATA_W  = 16,
   parameter int DEPTH   = 256,
   parameter int CNT_W   = 8,
   parameter int THR_RST = 0,
   localparam int MEM_AW = $clog2(DEPTH),
   localparam int BUS_AW = MEM_AW + 1,
   localparam int HAM_W  = ecc_ram_pkg::hamming_bits(DATA_W),
   localparam int CHK_W  = HAM_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic              bus_re,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_rvalid,
   output logic              nmi_o,
   output logic              thr_irq_o
);
   import ecc_ram_pkg::*;

   if (DATA_W < 4 || DATA_W > 64) begin : g_bad_dw
      $error("DATA_W must lie in 4..64");
   end
   if ((1 << MEM_AW) != DEPTH || MEM_AW < REG_IDX_W) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 8");
   end
   if (MEM_AW > DATA_W || CNT_W > DATA_W || CNT_W < 2) begin : g_bad_cnt
      $error("CNT_W and address width must fit the data bus");
   end

   logic [MEM_AW-1:0] maddr, addr_q;
   logic              is_reg, mem_we, mem_re, csr_we, test_mode;
   logic              rv_q, reg_sel_q;
   logic [CHK_W-1:0]  wchk, rchk;
   logic [DATA_W-1:0] raw_data, fixed, csr_rdata, reg_rd_q;
   logic              dec_single, dec_double, mem_evt, ce_evt, ue_evt;

   assign maddr  = bus_addr[MEM_AW-1:0];
   assign is_reg = bus_addr[BUS_AW-1];
   assign mem_we = bus_we && !is_reg;
   assign mem_re = bus_re && !bus_we && !is_reg;
   assign csr_we = bus_we && is_reg;

   secded_enc #(.DW(DATA_W)) u_enc (
      .data (bus_wdata),
      .chk  (wchk)
   );

   ecc_store #(.DW(DATA_W), .CW(CHK_W), .DEPTH(DEPTH)) u_store (
      .clk     (clk),
      .we_data (mem_we),
      .we_chk  (mem_we && !test_mode),
      .re      (mem_re),
      .addr    (maddr),
      .wdata   (bus_wdata),
      .wchk    (wchk),
      .rdata   (raw_data),
      .rchk    (rchk)
   );

   secded_dec #(.DW(DATA_W)) u_dec (
      .data       (raw_data),
      .chk        (rchk),
      .fixed      (fixed),
      .err_single (dec_single),
      .err_double (dec_double)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rv_q      <= 1'b0;
         reg_sel_q <= 1'b0;
         addr_q    <= '0;
         reg_rd_q  <= '0;
      end else begin
         rv_q      <= bus_re && !bus_we;
         reg_sel_q <= is_reg;
         addr_q    <= maddr;
         reg_rd_q  <= csr_rdata;
      end
   end

   assign mem_evt = rv_q && !reg_sel_q;
   assign ce_evt  = mem_evt && dec_single;
   assign ue_evt  = mem_evt && dec_double;

   ecc_csr #(.DW(DATA_W), .AW(MEM_AW), .CNT_W(CNT_W), .THR_RST(THR_RST)) u_csr (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (csr_we),
      .wr_idx    (bus_addr[REG_IDX_W-1:0]),
      .wr_data   (bus_wdata[CNT_W-1:0]),
      .rd_idx    (bus_addr[REG_IDX_W-1:0]),
      .ce_evt    (ce_evt),
      .ue_evt    (ue_evt),
      .evt_addr  (addr_q),
      .rd_data   (csr_rdata),
      .test_mode (test_mode),
      .nmi_o     (nmi_o),
      .thr_irq_o (thr_irq_o)
   );

   assign bus_rvalid = rv_q;
   assign bus_rdata  = reg_sel_q ? reg_rd_q : fixed;

   p_rvalid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && !bus_we) |=> bus_rvalid);

   p_no_spurious_rvalid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_re && !bus_we) |=> !bus_rvalid);

   p_flags_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(ce_evt && ue_evt));

endmodule

// File: tb/tb_ecc_ram_top.sv
module tb_ecc_ram_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0, bus_re = 1'b0;
   logic [8:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        bus_rvalid, nmi_o, thr_irq_o;

   int n_chk = 0, n_fail = 0, irq_seen = 0, exp_irq = 0, exp_cnt = 0;
   bit done = 0;

   localparam logic [8:0] A_CTRL = 9'h100, A_STAT = 9'h101, A_EADDR = 9'h102,
                          A_THR = 9'h103, A_CNT = 9'h104;

   ecc_ram_top dut (.*);

   always #10 clk = ~clk;

   always @(posedge clk) if (rst_n && thr_irq_o) irq_seen++;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(logic [8:0] a, logic [15:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(logic [8:0] a, output logic [15:0] d);
      @(negedge clk);
      bus_re = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_re = 1'b0;
      chk("R7 rvalid", {31'b0, bus_rvalid}, 32'd1);
      d = bus_rdata;
      @(negedge clk);
   endtask

   // model of reach-and-restart counting for each correctable read
   task automatic model_ce(int thr);
      exp_cnt++;
      if (thr != 0 && exp_cnt >= thr) begin
         exp_cnt = 0;
         exp_irq++;
      end
   endtask

   task automatic t_reset_state();
      logic [15:0] d;
      chk("R9 rvalid idle", {31'b0, bus_rvalid}, 0);
      chk("R9 nmi", {31'b0, nmi_o}, 0);
      chk("R9 irq", {31'b0, thr_irq_o}, 0);
      rd(A_CTRL, d);  chk("R9 ctrl", d, 0);
      rd(A_STAT, d);  chk("R9 status", d, 0);
      rd(A_EADDR, d); chk("R9 erraddr", d, 0);
      rd(A_THR, d);   chk("R9 thresh", d, 0);
      rd(A_CNT, d);   chk("R9 count", d, 0);
   endtask

   task automatic t_normal_rw();
      logic [15:0] d;
      wr(9'h005, 16'hA5C3);
      wr(9'h000, 16'h0000);
      wr(9'h0FF, 16'hFFFF);
      wr(9'h080, 16'h1234);
      rd(9'h005, d); chk("R1 mixed", d, 16'hA5C3);
      rd(9'h000, d); chk("R1 zeros at low addr", d, 16'h0000);
      rd(9'h0FF, d); chk("R1 ones at top addr (R10)", d, 16'hFFFF);
      rd(9'h080, d); chk("R1 mid", d, 16'h1234);
      rd(A_STAT, d); chk("R1 no error flag", d, 0);
   endtask

   task automatic t_single_inject();
      logic [15:0] d;
      wr(9'h030, 16'h0054);
      wr(9'h031, 16'h0054);
      wr(A_CTRL, 16'h0001);
      rd(A_CTRL, d); chk("R10 ctrl test bit", d, 1);
      wr(9'h030, 16'h0055);
      rd(9'h030, d); chk("R3 corrected bit0", d, 16'h0054);
      model_ce(0);
      rd(A_STAT, d);  chk("R4 ce flag set (R2)", d, 1);
      rd(A_EADDR, d); chk("R5 erraddr", d, 16'h0030);
      wr(9'h031, 16'h8054);
      rd(9'h031, d); chk("R3 corrected bit15", d, 16'h0054);
      model_ce(0);
      rd(A_EADDR, d); chk("R5 erraddr latest", d, 16'h0031);
      rd(A_CNT, d);   chk("R8 count no threshold", d, exp_cnt);
      chk("R8 thresh 0 never fires", irq_seen, 0);
   endtask

   task automatic t_w1c();
      logic [15:0] d;
      wr(A_STAT, 16'h0000);
      rd(A_STAT, d);  chk("R4 write 0 keeps flag", d, 1);
      wr(A_EADDR, 16'h0000);
      rd(A_EADDR, d); chk("R5 erraddr read-only", d, 16'h0031);
      wr(A_STAT, 16'h0001);
      rd(A_STAT, d);  chk("R4 w1c clears", d, 0);
   endtask

   task automatic t_double_inject();
      logic [15:0] d;
      wr(A_CTRL, 16'h0000);
      wr(9'h040, 16'h1234);
      wr(A_CTRL, 16'h0001);
      wr(9'h040, 16'h1234 ^ 16'h0011);
      rd(9'h040, d);
      @(negedge clk);
      chk("R6 nmi high", {31'b0, nmi_o}, 1);
      rd(A_STAT, d);  chk("R6 ue only", d, 2);
      rd(A_EADDR, d); chk("R6 erraddr untouched", d, 16'h0031);
      wr(A_STAT, 16'h0002);
      @(negedge clk);
      chk("R6 nmi cleared", {31'b0, nmi_o}, 0);
   endtask

   task automatic t_rewrite();
      logic [15:0] d;
      wr(A_CTRL, 16'h0000);
      wr(9'h030, 16'hBEEF);
      rd(9'h030, d);  chk("R1 rewrite after inject", d, 16'hBEEF);
      rd(A_STAT, d);  chk("R1 rewrite no flag", d, 0);
   endtask

   task automatic t_threshold();
      logic [15:0] d;
      wr(A_THR, 16'd2);
      for (int k = 0; k < 3; k++) begin
         rd(9'h031, d);
         model_ce(2);
      end
      repeat (2) @(negedge clk);
      chk("R8 thresh 2 pulses", irq_seen, exp_irq);
      rd(A_CNT, d); chk("R8 count after thresh 2", d, exp_cnt);
      wr(A_THR, 16'd1);
      rd(9'h031, d);
      model_ce(1);
      repeat (2) @(negedge clk);
      chk("R8 thresh 1 first error", irq_seen, exp_irq);
      rd(A_CNT, d); chk("R8 count restarts", d, 0);
      wr(A_THR, 16'd0);
      rd(9'h031, d);
      model_ce(0);
      repeat (2) @(negedge clk);
      chk("R8 thresh 0 silent", irq_seen, exp_irq);
      rd(A_CNT, d); chk("R8 count thresh 0", d, exp_cnt);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_state();
      t_normal_rw();
      t_single_inject();
      t_w1c();
      t_double_inject();
      t_rewrite();
      t_threshold();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule